// File: doc/BRIEF.md
# Clocked Sequential Memory Port

This block is a synchronous, pointer-driven port into a word memory of 4096 entries of 16 bits. A 12-bit internal pointer picks the word that each clock edge touches. On any rising edge the pointer can be loaded from an address input, stepped forward by one, or left where it is. In the same edge the port may write the input word at the pointed location or capture the stored word into an output register.

The port is meant for streaming buffers. A producer or consumer loads a start address once and then moves through memory one word per cycle while the count enable is held. After a load the pointer stays on the loaded location for one extra edge. As a result, the first word after a load is accessed twice before stepping begins. An end-of-buffer flag rises for one cycle when the pointer steps onto the top address. The output bus has no tristate pad; it is a registered word plus a drive-enable bit.

Top module: `seq_port_mem`

## Requirements
- R1: With `load_n` low at a rising edge, the pointer takes `addr_in` on that edge. Any read or write on that same edge uses `addr_in` as its address.
- R2: With `load_n` high, `cnt_en_n` low and the previous edge not a load, the pointer steps by one. It wraps from 4095 to 0. The access on that edge uses the pointer value held before the step.
- R3: With `load_n` high and `cnt_en_n` high, the pointer keeps its value.
- R4: On the edge right after a load edge, the pointer does not step, even with `cnt_en_n` low.
- R5: When `load_n` and `cnt_en_n` are both low, the load wins: the pointer takes `addr_in` and does not step.
- R6: With `ce_n` low and `rd_wr` low (0 = write) at an edge, `din` is stored at that edge's address.
- R7: With `ce_n` low and `rd_wr` high (1 = read) at an edge, `dout` shows the word at that edge's address from that edge on. In every other case `dout` keeps its value.
- R8: `dout_en` is 1 after an edge only if that edge had `ce_n` low, `rd_wr` high and `oe_n` low. Otherwise it is 0.
- R9: With `ce_n` high, no word is read or written, but the pointer still loads, steps or holds as R1 to R5 describe.
- R10: `eob` is 1 for exactly the cycle that follows an edge where the pointer stepped onto 4095. A load edge or reset leaves it 0.
- R11: Reset (`rst_n` low, asynchronous) sets the pointer to 0, clears the load-freeze condition, and clears `eob`, `dout_en` and `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low pointer load |
| addr_in | input | 12 | Address loaded into the pointer |
| cnt_en_n | input | 1 | Active-low pointer step enable |
| ce_n | input | 1 | Active-low access enable |
| rd_wr | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Active-low output drive request |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data |
| dout_en | output | 1 | High when `dout` would be driven onto the bus |
| eob | output | 1 | End-of-buffer pulse |

## Verification
Every result of this port comes one register stage after the edge that samples its controls. The stored word, the new pointer, `dout`, `dout_en` and `eob` all take their values on that edge. The pointer is observed only through `dout`, so a step shows up in the word returned by the next read edge. The bench applies each stimulus at a falling edge and updates its model at the next rising edge. It compares all three outputs at the following falling edge, half a period after the edge that produced them. An asynchronous reset is checked one time unit after it is asserted, before any clock edge.

// File: rtl/seq_port_pkg.sv
package seq_port_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } acc_kind_e;

    function automatic acc_kind_e decode_access(input logic sel_n, input logic rd_not_wr);
        if (sel_n)
            return ACC_IDLE;
        else if (rd_not_wr)
            return ACC_READ;
        else
            return ACC_WRITE;
    endfunction

endpackage

// File: rtl/seq_ptr_ctrl.sv
module seq_ptr_ctrl #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cnt_en_n,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              eob
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              frozen;
        logic              eob;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [ADDR_W-1:0] ptr_next;

    assign ptr_next = st_q.ptr + 1'b1;

    // Address used by the access on this edge: a load redirects it at once
    assign eff_addr = load_n ? st_q.ptr : addr_in;
    assign eob      = st_q.eob;

    always_comb begin
        st_d        = st_q;
        st_d.frozen = 1'b0;
        st_d.eob    = 1'b0;
        if (!load_n) begin
            st_d.ptr    = addr_in;
            st_d.frozen = 1'b1;
        end else if (!cnt_en_n && !st_q.frozen) begin
            st_d.ptr = ptr_next;
            st_d.eob = (ptr_next == LAST_ADDR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R1: a load places addr_in in the pointer
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> st_q.ptr == $past(addr_in));

    // R2: an enabled step adds one, modulo the array size
    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !st_q.frozen) |=> st_q.ptr == ADDR_W'($past(st_q.ptr) + 1'b1));

    // R3: step disabled keeps the pointer
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> $stable(st_q.ptr));

    // R4: the edge after a load never steps
    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && st_q.frozen) |=> $stable(st_q.ptr));

    // R5: load wins over a concurrent step request
    p_load_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !cnt_en_n) |=> (st_q.ptr == $past(addr_in) && st_q.frozen));

    // R10: the flag is only ever up while the pointer sits on the top address
    p_eob_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eob |-> st_q.ptr == LAST_ADDR);

    p_eob_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eob |=> !st_q.eob);

endmodule

// File: rtl/seq_word_store.sv
module seq_word_store
    import seq_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (acc == ACC_WRITE)
            mem[addr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (acc == ACC_READ)
            rdata_d = mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R6: a write edge leaves the word in the addressed location
    p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_WRITE) |=> mem[$past(addr)] == $past(wdata));

    // R7: the read register moves only on a read edge
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_READ) |=> $stable(rdata_q));

endmodule

// File: rtl/seq_port_mem.sv
module seq_port_mem
    import seq_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cnt_en_n,
    input  logic              ce_n,
    input  logic              rd_wr,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              eob
);
    acc_kind_e         acc;
    logic [ADDR_W-1:0] eff_addr;
    logic              drive_d, drive_q;

    assign acc = decode_access(ce_n, rd_wr);

    seq_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .addr_in  (addr_in),
        .cnt_en_n (cnt_en_n),
        .eff_addr (eff_addr),
        .eob      (eob)
    );

    seq_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .addr  (eff_addr),
        .wdata (din),
        .rdata (dout)
    );

    always_comb begin
        drive_d = (acc == ACC_READ) && !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            drive_q <= 1'b0;
        else
            drive_q <= drive_d;
    end

    assign dout_en = drive_q;

    // R8: drive only after a read edge with the output requested
    p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!$past(ce_n) && $past(rd_wr) && !$past(oe_n)));

    // R9: a deselected edge leaves the read data untouched
    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(dout));

endmodule

// File: tb/seq_port_mem_test.sv
module seq_port_mem_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          cnt_en_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          rd_wr = 1'b1;
    logic          oe_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          eob;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference
    logic [DW-1:0] m_mem [DEPTH];
    int            m_ptr;
    bit            m_just_loaded;
    bit            m_eob;
    bit            m_den;
    logic [DW-1:0] m_dout;

    seq_port_mem #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .addr_in(addr_in),
        .cnt_en_n(cnt_en_n), .ce_n(ce_n), .rd_wr(rd_wr), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_en(dout_en), .eob(eob)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic model_reset();
        m_ptr = 0; m_just_loaded = 0; m_eob = 0; m_den = 0; m_dout = '0;
    endtask

    task automatic model_edge();
        int ea;
        ea = load_n ? m_ptr : int'(addr_in);
        if (!ce_n && !rd_wr) m_mem[ea] = din;
        if (!ce_n && rd_wr)  m_dout = m_mem[ea];
        m_den = !ce_n && rd_wr && !oe_n;
        if (!load_n) begin
            m_ptr = int'(addr_in); m_just_loaded = 1; m_eob = 0;
        end else if (!cnt_en_n && !m_just_loaded) begin
            m_ptr = (m_ptr + 1) % DEPTH; m_eob = (m_ptr == DEPTH-1); m_just_loaded = 0;
        end else begin
            m_eob = 0; m_just_loaded = 0;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (dout !== m_dout) begin
            failures++;
            $display("FAIL %s (R7 data) dout actual=%h expected=%h", tag, dout, m_dout);
        end
        checks++;
        if (dout_en !== m_den) begin
            failures++;
            $display("FAIL %s (R8 drive) dout_en actual=%b expected=%b", tag, dout_en, m_den);
        end
        checks++;
        if (eob !== m_eob) begin
            failures++;
            $display("FAIL %s (R10 flag) eob actual=%b expected=%b", tag, eob, m_eob);
        end
    endtask

    task automatic drive(input bit ld, input int a, input bit cen, input bit ce,
                         input bit rw, input bit oe, input int d);
        load_n = ld; addr_in = AW'(a); cnt_en_n = cen; ce_n = ce;
        rd_wr = rw; oe_n = oe; din = DW'(d);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1 compare("R11 reset state");
        rst_n = 1'b1;

        // R1 R6: load 0 and write on the same edge
        drive(0, 0, 1, 0, 0, 1, 16'h1111);
        step("R1 R6 load-write");
        // R2 R4 R6 R10: stream-write the whole array and wrap past 4095
        for (int i = 0; i < DEPTH + 4; i++) begin
            drive(1, 0, 0, 0, 0, 1, (i * 37) ^ 16'hA5C3);
            step("R2 R4 R10 fill");
        end

        // R1 R7 R8: load with read, output requested
        drive(0, 100, 1, 0, 1, 0, 0);
        step("R1 R7 R8 load-read");
        // R4: frozen edge then steps
        for (int i = 0; i < 6; i++) begin
            drive(1, 0, 0, 0, 1, 0, 0);
            step("R2 R4 stream-read");
        end
        // R3: hold
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 1, 0, 1, 0, 0);
            step("R3 hold");
        end
        // R5: load while counting enabled
        drive(0, 2000, 0, 0, 1, 0, 0);
        step("R5 load priority");
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 0, 0, 1, 0, 0);
            step("R5 after load");
        end
        // R9: deselected with steps and a write attempt
        for (int i = 0; i < 4; i++) begin
            drive(1, 0, 0, 1, (i % 2), 0, 16'hDEAD);
            step("R9 deselect");
        end
        drive(1, 0, 1, 0, 1, 0, 0);
        step("R9 pointer moved");
        // R8: read with output not requested
        drive(1, 0, 0, 0, 1, 1, 0);
        step("R8 oe high");
        drive(1, 0, 0, 0, 1, 0, 0);
        step("R8 oe low");
        // R10: approach top address after a load
        drive(0, 4093, 0, 0, 1, 0, 0);
        step("R10 load near top");
        for (int i = 0; i < 5; i++) begin
            drive(1, 0, 0, 0, 1, 0, 0);
            step("R10 top pulse");
        end
        // R10: load onto 4095 raises no flag
        drive(0, 4095, 0, 0, 1, 0, 0);
        step("R10 load top");
        drive(1, 0, 0, 0, 1, 0, 0);
        step("R10 frozen top");
        // R11: asynchronous reset mid-run
        drive(1, 0, 1, 1, 1, 1, 0);
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        #1 compare("R11 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 0, 1, 0, 1, 0, 0);
        step("R11 pointer zero");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule